// File: doc/BRIEF.md
# Encoder Electrical Angle Tracker

This block follows a free-running 32-bit incremental encoder count and reduces it to a position inside one electrical period, the phase-table period. It keeps an offset register and subtracts it from the count. When the difference leaves the range from 0 to period-1, the offset moves by exactly one period. The in-range index is then multiplied by a stored reciprocal of the period. The result is a 32-bit angle that sweeps its full range once per period. Its upper bits can drive a sine/cosine approximator downstream.

Work happens only on an update strobe. The first strobe after reset captures the encoder count into the offset, so tracking starts at index zero. A register stage holds the index, offset and angle, and a one-cycle valid pulse appears in the cycle after each strobe. Period and reciprocal are staged configuration registers. A value written in any cycle before a strobe is the one that strobe uses.

Top module: `enc_angle_tracker`

## Requirements
- R1: While reset is held and after it, until the first strobe, `out_vld` is 0 and `phase_idx`, `offset` and `angle` are 0.
- R2: The first strobe after reset loads `offset` with `enc_cnt` and gives `phase_idx` = 0 and `angle` = 0.
- R3: On every later strobe, `phase_idx` equals `enc_cnt` minus the new `offset`, modulo 2^32.
- R4: If `enc_cnt` minus the old offset is ≥ period (taken as a non-negative value), the offset grows by one period. If it is negative (bit 31 set), the offset shrinks by one period. Otherwise the offset is unchanged.
- R5: `angle` equals the low 32 bits of `phase_idx` multiplied by the reciprocal in use at that strobe.
- R6: After reset, the period is 1000 and the reciprocal is 4294967.
- R7: Writes through `prd_wr`/`rcp_wr` do not change any output by themselves. A strobe one or more cycles later uses the written values.
- R8: `out_vld` is high in exactly the cycle after a strobe. Without a strobe, `phase_idx`, `offset` and `angle` hold their values.
- R9: Encoder counts that cross the 2^32 wrap are tracked without a jump in `phase_idx`, which stays inside 0..period-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enc_cnt | input | 32 | Free-running encoder count |
| upd_stb | input | 1 | Update strobe |
| prd_wr | input | 1 | Period write enable |
| prd_wdata | input | 32 | New period value |
| rcp_wr | input | 1 | Reciprocal write enable |
| rcp_wdata | input | 32 | New reciprocal value |
| phase_idx | output | 32 | Index inside the current period |
| offset | output | 32 | Current offset register |
| angle | output | 32 | Scaled angle, full range per period |
| out_vld | output | 1 | One-cycle pulse after each strobe |

## Verification
The range assertion assumes two things. The encoder moves by less than one period between strobes, and the period is non-zero and below 2^31. A single offset correction per strobe cannot restore the range otherwise. The bench walks the count in steps of at most seven between strobes with an 8-count period. It changes the period only while the index sits at zero, so the old index is already valid under the new period. Writes are never issued in the same cycle as a strobe.

// File: rtl/enc_angle_pkg.sv
package enc_angle_pkg;

    localparam int unsigned ANG_W = 32;

    typedef logic [ANG_W-1:0] word_t;

    typedef enum logic [1:0] {
        WRAP_NONE = 2'd0,
        WRAP_UP   = 2'd1,
        WRAP_DOWN = 2'd2
    } wrap_e;

    typedef struct packed {
        word_t idx;
        word_t off;
        wrap_e dir;
    } track_t;

    // Decide which way the offset has to move for a raw difference.
    function automatic wrap_e classify(input word_t raw, input word_t prd);
        if (raw[ANG_W-1])
            return WRAP_DOWN;
        else if (raw >= prd)
            return WRAP_UP;
        else
            return WRAP_NONE;
    endfunction

endpackage

// File: rtl/enc_cfg_regs.sv
module enc_cfg_regs
    import enc_angle_pkg::*;
#(
    parameter word_t DEF_PRD = word_t'(1000),
    parameter word_t DEF_RCP = word_t'(4294967)
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  prd_wr,
    input  word_t prd_wdata,
    input  logic  rcp_wr,
    input  word_t rcp_wdata,
    output word_t prd_q,
    output word_t rcp_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            prd_q <= DEF_PRD;
            rcp_q <= DEF_RCP;
        end else begin
            if (prd_wr) prd_q <= prd_wdata;
            if (rcp_wr) rcp_q <= rcp_wdata;
        end
    end

endmodule

// File: rtl/enc_wrap_unit.sv
module enc_wrap_unit
    import enc_angle_pkg::*;
(
    input  logic   started,
    input  word_t  enc,
    input  word_t  off_cur,
    input  word_t  prd,
    output track_t res
);

    word_t raw;
    wrap_e dir;

    always_comb begin
        raw = enc - off_cur;
        dir = classify(raw, prd);
        res = '{idx: raw, off: off_cur, dir: WRAP_NONE};
        if (!started) begin
            res.off = enc;
            res.idx = '0;
        end else begin
            res.dir = dir;
            unique case (dir)
                WRAP_UP: begin
                    res.off = off_cur + prd;
                    res.idx = raw - prd;
                end
                WRAP_DOWN: begin
                    res.off = off_cur - prd;
                    res.idx = raw + prd;
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/enc_angle_scale.sv
module enc_angle_scale
    import enc_angle_pkg::*;
#(
    parameter int unsigned PROD_W = 2 * ANG_W
) (
    input  word_t idx,
    input  word_t rcp,
    output word_t ang
);

    logic [PROD_W-1:0] prod;

    generate
        if (PROD_W > ANG_W) begin : g_wide
            always_comb prod = PROD_W'(idx) * PROD_W'(rcp);
        end else begin : g_narrow
            always_comb prod = idx * rcp;
        end
    endgenerate

    assign ang = prod[ANG_W-1:0];

endmodule

// File: rtl/enc_angle_tracker.sv
module enc_angle_tracker
    import enc_angle_pkg::*;
#(
    parameter word_t DEF_PRD = word_t'(1000),
    parameter word_t DEF_RCP = word_t'(4294967)
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [31:0] enc_cnt,
    input  logic        upd_stb,
    input  logic        prd_wr,
    input  logic [31:0] prd_wdata,
    input  logic        rcp_wr,
    input  logic [31:0] rcp_wdata,
    output logic [31:0] phase_idx,
    output logic [31:0] offset,
    output logic [31:0] angle,
    output logic        out_vld
);

    word_t  prd_q;
    word_t  rcp_q;
    logic   started;
    track_t nxt;
    word_t  ang_nxt;

    enc_cfg_regs #(
        .DEF_PRD (DEF_PRD),
        .DEF_RCP (DEF_RCP)
    ) cfg_i (
        .clk       (clk),
        .rst       (rst),
        .prd_wr    (prd_wr),
        .prd_wdata (prd_wdata),
        .rcp_wr    (rcp_wr),
        .rcp_wdata (rcp_wdata),
        .prd_q     (prd_q),
        .rcp_q     (rcp_q)
    );

    enc_wrap_unit wrap_i (
        .started (started),
        .enc     (enc_cnt),
        .off_cur (offset),
        .prd     (prd_q),
        .res     (nxt)
    );

    enc_angle_scale scale_i (
        .idx (nxt.idx),
        .rcp (rcp_q),
        .ang (ang_nxt)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            started   <= 1'b0;
            phase_idx <= '0;
            offset    <= '0;
            angle     <= '0;
            out_vld   <= 1'b0;
        end else begin
            out_vld <= upd_stb;
            if (upd_stb) begin
                started   <= 1'b1;
                phase_idx <= nxt.idx;
                offset    <= nxt.off;
                angle     <= ang_nxt;
            end
        end
    end

endmodule

// File: rtl/enc_angle_tracker_chk.sv
module enc_angle_tracker_chk (
    input logic        clk,
    input logic        rst,
    input logic [31:0] enc_cnt,
    input logic        upd_stb,
    input logic [31:0] phase_idx,
    input logic [31:0] offset,
    input logic [31:0] angle,
    input logic        out_vld,
    input logic [31:0] prd_q,
    input logic [31:0] rcp_q,
    input logic        started
);

    // R2
    first_load_chk: assert property (@(posedge clk) disable iff (rst)
        upd_stb && !started |=> phase_idx == 32'd0 && offset == $past(enc_cnt));

    // R3
    index_relation_chk: assert property (@(posedge clk) disable iff (rst)
        upd_stb && started |=> phase_idx == $past(enc_cnt) - offset);

    // R4
    offset_step_chk: assert property (@(posedge clk) disable iff (rst)
        upd_stb && started |=> (offset == $past(offset)) ||
                               (offset - $past(offset) == $past(prd_q)) ||
                               ($past(offset) - offset == $past(prd_q)));

    // R5
    angle_scale_chk: assert property (@(posedge clk) disable iff (rst)
        upd_stb |=> angle == 32'(phase_idx * $past(rcp_q)));

    // R8
    valid_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        upd_stb |=> out_vld);

    // R8
    valid_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !upd_stb |=> !out_vld);

    // R8
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        !upd_stb |=> $stable(offset) && $stable(phase_idx) && $stable(angle));

    // R9
    in_range_chk: assert property (@(posedge clk) disable iff (rst)
        upd_stb |=> phase_idx < $past(prd_q));

endmodule

bind enc_angle_tracker enc_angle_tracker_chk chk_i (
    .clk       (clk),
    .rst       (rst),
    .enc_cnt   (enc_cnt),
    .upd_stb   (upd_stb),
    .phase_idx (phase_idx),
    .offset    (offset),
    .angle     (angle),
    .out_vld   (out_vld),
    .prd_q     (prd_q),
    .rcp_q     (rcp_q),
    .started   (started)
);

// File: tb/enc_angle_tracker_tb.sv
module enc_angle_tracker_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] enc_cnt = '0;
    logic        upd_stb = 1'b0;
    logic        prd_wr = 1'b0;
    logic [31:0] prd_wdata = '0;
    logic        rcp_wr = 1'b0;
    logic [31:0] rcp_wdata = '0;
    logic [31:0] phase_idx;
    logic [31:0] offset;
    logic [31:0] angle;
    logic        out_vld;

    int checks = 0;
    int failures = 0;

    logic [31:0] m_off;
    logic [31:0] m_idx;
    logic [31:0] m_prd;
    logic [31:0] m_rcp;
    logic [15:0] lfsr = 16'hACE1;

    always #5 clk = ~clk;

    enc_angle_tracker dut_i (
        .clk       (clk),
        .rst       (rst),
        .enc_cnt   (enc_cnt),
        .upd_stb   (upd_stb),
        .prd_wr    (prd_wr),
        .prd_wdata (prd_wdata),
        .rcp_wr    (rcp_wr),
        .rcp_wdata (rcp_wdata),
        .phase_idx (phase_idx),
        .offset    (offset),
        .angle     (angle),
        .out_vld   (out_vld)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        m_prd = 32'd1000;
        m_rcp = 32'd4294967;
    endtask

    // Strobe with a new count; model follows the requirement rule.
    task automatic strobe(input logic [31:0] enc, input bit first, input string req);
        logic [31:0] raw;
        enc_cnt = enc;
        upd_stb = 1'b1;
        @(negedge clk);
        upd_stb = 1'b0;
        if (first) begin
            m_off = enc;
            m_idx = 32'd0;
        end else begin
            raw = enc - m_off;
            if (raw[31]) m_off = m_off - m_prd;
            else if (raw >= m_prd) m_off = m_off + m_prd;
            m_idx = enc - m_off;
        end
        chk({req, " vld"}, {31'd0, out_vld}, 32'd1);
        chk({req, " idx"}, phase_idx, m_idx);
        chk({req, " off"}, offset, m_off);
        chk({req, " ang"}, angle, m_idx * m_rcp);
        @(negedge clk);
        chk({req, " vld drop R8"}, {31'd0, out_vld}, 32'd0);
    endtask

    task automatic write_cfg(input logic [31:0] p, input logic [31:0] r);
        prd_wr = 1'b1; prd_wdata = p;
        rcp_wr = 1'b1; rcp_wdata = r;
        @(negedge clk);
        prd_wr = 1'b0; rcp_wr = 1'b0;
        m_prd = p;
        m_rcp = r;
    endtask

    task automatic walk(input int n, input bit up_only, input string req);
        logic [31:0] e;
        e = enc_cnt;
        for (int i = 0; i < n; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            if (up_only) e = e + 32'(lfsr[2:0]);
            else e = e + 32'(int'(lfsr[3:0] % 15) - 7);
            strobe(e, 1'b0, req);
        end
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin : main
        logic [31:0] i0, o0, a0;
        do_reset();
        // R1: reset state
        chk("R1 vld", {31'd0, out_vld}, 32'd0);
        chk("R1 idx", phase_idx, 32'd0);
        chk("R1 off", offset, 32'd0);
        chk("R1 ang", angle, 32'd0);

        // R2: initial capture
        strobe(32'd12345, 1'b1, "R2");
        // R6 + R4: default period and reciprocal
        strobe(32'd13344, 1'b0, "R6 top of range");
        chk("R6 angle value", angle, 32'd999 * 32'd4294967);
        strobe(32'd13345, 1'b0, "R4 wrap up");
        chk("R4 off up", offset, 32'd13345);
        strobe(32'd13344, 1'b0, "R4 wrap down");
        chk("R4 off down", offset, 32'd12345);
        chk("R3 idx down", phase_idx, 32'd999);
        strobe(32'd12345, 1'b0, "R3 back to zero");

        // R7: writes alone change nothing
        i0 = phase_idx; o0 = offset; a0 = angle;
        write_cfg(32'd8, 32'h2000_0000);
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            chk("R7 no vld", {31'd0, out_vld}, 32'd0);
            chk("R7 idx hold", phase_idx, i0);
            chk("R7 off hold", offset, o0);
            chk("R7 ang hold", angle, a0);
        end
        strobe(32'd12353, 1'b0, "R7 new period");
        chk("R7 off moved by 8", offset, 32'd12353);

        // R3/R4/R5: walk both ways
        walk(1500, 1'b0, "R5 walk");

        // R9: crossing the 2^32 wrap
        do_reset();
        chk("R1 after re-reset", offset, 32'd0);
        write_cfg(32'd8, 32'h2000_0000);
        strobe(32'hFFFF_FF00, 1'b1, "R2 high start");
        walk(300, 1'b1, "R9 cross wrap");
        chk("R9 crossed", {31'd0, enc_cnt < 32'h0000_1000}, 32'd1);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule